// File: doc/BRIEF.md
# Card Bus Access Strobe Sequencer

This block times a single access on a removable-card bus. A start request carries the address space (common memory, attribute memory or I/O), the direction and three cycle counts taken from the selected window's timing fields. The sequencer then runs three phases in a fixed order. In the address setup phase no strobe is active. In the strobe phase the strobe that matches the space and direction is driven low. The hold phase follows, and then the sequencer reports completion with a one-cycle done pulse.

A bus monitor counts the active cycles of each access. An access that would need more cycles than the limit allows is abandoned with a one-cycle error pulse in place of done. A socket reset input abandons any access at once. A socket output-enable control, active low, keeps every strobe inactive while it is deasserted. The phases still run to completion in that case. Address decoding and the data path belong to neighbouring blocks.

The controller has four states. `ST_IDLE` goes to `ST_SETUP` when a start is accepted. `ST_SETUP` goes to `ST_STROBE`, `ST_STROBE` goes to `ST_HOLD`, and `ST_HOLD` returns to `ST_IDLE`. Each of these three steps is taken on the last cycle of the current phase, and the final one raises done. Any busy state returns to `ST_IDLE` on a bus-monitor abort, which raises the error pulse, or on socket reset, which raises no pulse.

Top module: `card_strobe_seq`

## Requirements
- R1: After `rst_n` is released, `busy`, `done` and `err` are low, and every strobe and `attr_sel_n` is high.
- R2: A start sampled at clock edge E0 gives setup cycles 1..S, strobe cycles S+1..S+L and hold cycles S+L+1..S+L+H, counting the cycles after E0. A strobe is low only in the strobe phase.
- R3: A phase count of zero lasts exactly one cycle.
- R4: The `space` code selects the strobe: 2'b00 is common memory, 2'b01 is attribute memory, and 2'b1x is I/O. For the memory spaces, a read drives `mem_oe_n` and a write (`write`=1) drives `mem_we_n`. For I/O, a read drives `io_rd_n` and a write drives `io_wr_n`. At most one strobe is low at a time.
- R5: For space 2'b01, `attr_sel_n` is low in every active cycle of the access. For the other spaces it stays high.
- R6: `done` is high for exactly one cycle, T+1 with T=S+L+H, and `busy` is low in that cycle.
- R7: With the default limit of 60, an access of 59 cycles or fewer completes with done. A longer access stops after 59 active cycles and raises `err` for one cycle (cycle 60) with no done.
- R8: A start request that arrives while `busy` is high is ignored and does not change the running access.
- R9: While `oe_ctl_n` is high, all strobes stay high, but the phases and `done` keep their timing.
- R10: `sock_reset` high abandons the access: in the next cycle `busy` is low and no `done` or `err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sock_reset | input | 1 | Socket reset, active high, abandons an access |
| oe_ctl_n | input | 1 | Socket output-enable control, active low |
| start | input | 1 | Access request, sampled in idle |
| space | input | 2 | 00 common, 01 attribute, 1x I/O |
| write | input | 1 | 1 = write, 0 = read |
| setup_cnt | input | CNT_W | Setup phase cycles (0 means 1) |
| strobe_cnt | input | CNT_W | Strobe phase cycles (0 means 1) |
| hold_cnt | input | CNT_W | Hold phase cycles (0 means 1) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle bus-monitor abort pulse |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| attr_sel_n | output | 1 | Attribute-memory select, active low |

## Verification
Each access is launched so that the start is taken at a known edge E0. The bench then samples at every falling edge and numbers those samples as cycles 1, 2 and so on after E0. Its expectations follow from the effective counts: a strobe is low from cycle S+1 to S+L, with the window cut off at 59 when the bus monitor fires. Done is due in cycle T+1, err in cycle 60, and `busy` is due low in the cycle after a socket reset. Each scenario records the first cycle and the total count of every output event over a 72-cycle window and compares them with these values. A wrong duration, an early or late pulse, or a strobe of the wrong kind shows up as a mismatch.

// File: rtl/card_strobe_pkg.sv
package card_strobe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    localparam logic [1:0] SPACE_COMMON = 2'b00;
    localparam logic [1:0] SPACE_ATTR   = 2'b01;

endpackage

// File: rtl/cs_phase_timer.sv
module cs_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Zero is treated as one cycle: the counter then starts already at its final value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_zero_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> last);

endmodule

// File: rtl/cs_bus_monitor.sv
module cs_bus_monitor #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic at_limit
);

    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST_OK = W'(LIMIT - 1);

    logic [W-1:0] elapsed_q;

    // Holds the number of the current active cycle; it saturates at the last one allowed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (clr) begin
            elapsed_q <= W'(1);
        end else if (run && elapsed_q != LAST_OK) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign at_limit = run && (elapsed_q == LAST_OK);

    assert_within_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_q <= LAST_OK);

endmodule

// File: rtl/cs_strobe_decode.sv
module cs_strobe_decode (
    input  logic       active,
    input  logic       in_strobe,
    input  logic [1:0] space,
    input  logic       write,
    input  logic       oe_ctl_n,
    output logic       mem_oe_n,
    output logic       mem_we_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       attr_sel_n
);

    import card_strobe_pkg::*;

    logic fire;
    logic is_io;

    always_comb begin
        fire       = in_strobe && !oe_ctl_n;
        is_io      = space[1];
        mem_oe_n   = !(fire && !is_io && !write);
        mem_we_n   = !(fire && !is_io &&  write);
        io_rd_n    = !(fire &&  is_io && !write);
        io_wr_n    = !(fire &&  is_io &&  write);
        attr_sel_n = !(active && space == SPACE_ATTR);
    end

endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq #(
    parameter int CNT_W     = 5,
    parameter int BMT_LIMIT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sock_reset,
    input  logic             oe_ctl_n,
    input  logic             start,
    input  logic [1:0]       space,
    input  logic             write,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] strobe_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             io_rd_n,
    output logic             io_wr_n,
    output logic             attr_sel_n
);

    import card_strobe_pkg::*;

    seq_state_t       state_q, state_d;
    logic [1:0]       space_q;
    logic             write_q;
    logic [CNT_W-1:0] strobe_len_q, hold_len_q;
    logic             done_q, err_q;

    logic             accept, finish, abort;
    logic             tmr_load, tmr_last, at_limit;
    logic [CNT_W-1:0] tmr_val;

    cs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    cs_bus_monitor #(.LIMIT(BMT_LIMIT)) u_bmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .run      (busy),
        .at_limit (at_limit)
    );

    // Next state and the phase-timer controls.
    always_comb begin
        accept   = (state_q == ST_IDLE) && start && !sock_reset;
        finish   = (state_q == ST_HOLD) && tmr_last;
        abort    = at_limit && !finish;
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = setup_cnt;
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = strobe_len_q;
                end
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = hold_len_q;
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort || sock_reset) begin
            state_d = ST_IDLE;
        end
    end

    // State register, the captured request and the result pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            space_q      <= '0;
            write_q      <= 1'b0;
            strobe_len_q <= '0;
            hold_len_q   <= '0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish && !sock_reset;
            err_q   <= abort && !sock_reset;
            if (accept) begin
                space_q      <= space;
                write_q      <= write;
                strobe_len_q <= strobe_cnt;
                hold_len_q   <= hold_cnt;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q;
        err  = err_q;
    end

    cs_strobe_decode u_decode (
        .active     (busy),
        .in_strobe  (state_q == ST_STROBE),
        .space      (space_q),
        .write      (write_q),
        .oe_ctl_n   (oe_ctl_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .attr_sel_n (attr_sel_n)
    );

    assert_strobe_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n || !io_rd_n || !io_wr_n) |-> (state_q == ST_STROBE));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~mem_oe_n, ~mem_we_n, ~io_rd_n, ~io_wr_n}) <= 1);

    assert_attr_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_sel_n |-> busy);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_no_done_with_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_busy_start_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(space_q) && $stable(write_q)));

    assert_strobes_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ctl_n |-> (mem_oe_n && mem_we_n && io_rd_n && io_wr_n));

    assert_reset_abandon_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sock_reset |=> (!busy && !done && !err));

endmodule

// File: tb/card_strobe_seq_tb.sv
module card_strobe_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 5;
    localparam int LIM        = 60;
    localparam int WIN        = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sock_reset = 1'b0;
    logic          oe_ctl_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    space = 2'b00;
    logic          write = 1'b0;
    logic [CW-1:0] setup_cnt = '0, strobe_cnt = '0, hold_cnt = '0;
    logic          busy, done, err, mem_oe_n, mem_we_n, io_rd_n, io_wr_n, attr_sel_n;

    int checks = 0;
    int failures = 0;

    card_strobe_seq #(.CNT_W(CW), .BMT_LIMIT(LIM)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sock_reset (sock_reset),
        .oe_ctl_n   (oe_ctl_n),
        .start      (start),
        .space      (space),
        .write      (write),
        .setup_cnt  (setup_cnt),
        .strobe_cnt (strobe_cnt),
        .hold_cnt   (hold_cnt),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .attr_sel_n (attr_sel_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    // Launch one access and observe it for WIN cycles after the start edge.
    // restart_k: cycle in which a second start is offered (0 = none).
    // rst_k: cycle in which sock_reset is pulsed (0 = none).
    task automatic run_access(input string req, input logic [1:0] sp, input logic wr,
                              input int s, input int l, input int h, input logic oe_n,
                              input int restart_k, input int rst_k);
        int cnt[4];
        int first_low, attr_cnt, done_at, done_n, err_at, err_n, busy_after_rst;
        int es, el, eh, t, lo, hi, exp_cnt, tgt, others, exp_attr;
        first_low = -1; attr_cnt = 0; done_at = -1; done_n = 0; err_at = -1; err_n = 0;
        busy_after_rst = -1;
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        @(negedge clk);
        oe_ctl_n = oe_n; space = sp; write = wr;
        setup_cnt = CW'(s); strobe_cnt = CW'(l); hold_cnt = CW'(h);
        start = 1'b1;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (!mem_oe_n) cnt[0]++;
            if (!mem_we_n) cnt[1]++;
            if (!io_rd_n)  cnt[2]++;
            if (!io_wr_n)  cnt[3]++;
            if (first_low < 0 && !(mem_oe_n && mem_we_n && io_rd_n && io_wr_n)) first_low = k;
            if (!attr_sel_n) attr_cnt++;
            if (done) begin done_n++; if (done_at < 0) done_at = k; end
            if (err)  begin err_n++;  if (err_at < 0) err_at = k; end
            if (rst_k != 0 && k == rst_k + 1) busy_after_rst = busy;
            sock_reset = (k == rst_k);
            if (restart_k != 0 && k == restart_k) begin
                start = 1'b1; space = 2'b10; write = ~wr;
                setup_cnt = '0; strobe_cnt = '0; hold_cnt = '0;
            end
        end
        sock_reset = 1'b0;
        oe_ctl_n = 1'b0;
        es = eff(s); el = eff(l); eh = eff(h); t = es + el + eh;
        tgt = sp[1] ? (wr ? 3 : 2) : (wr ? 1 : 0);
        others = cnt[0] + cnt[1] + cnt[2] + cnt[3] - cnt[tgt];
        if (rst_k != 0) begin
            check(busy_after_rst == 0, req, "busy after socket reset", busy_after_rst, 0);
            check(done_n == 0, req, "done pulses after abandon", done_n, 0);
            check(err_n == 0, req, "err pulses after abandon", err_n, 0);
            check(others == 0, req, "wrong-kind strobe cycles", others, 0);
        end else begin
            lo = es + 1;
            hi = (t > LIM - 1) ? ((es + el < LIM - 1) ? es + el : LIM - 1) : es + el;
            exp_cnt = oe_n ? 0 : ((hi >= lo) ? hi - lo + 1 : 0);
            exp_attr = (sp == 2'b01) ? ((t > LIM - 1) ? LIM - 1 : t) : 0;
            check(cnt[tgt] == exp_cnt, req, "strobe low cycles", cnt[tgt], exp_cnt);
            check(others == 0, req, "wrong-kind strobe cycles", others, 0);
            if (exp_cnt > 0)
                check(first_low == lo, req, "first strobe cycle", first_low, lo);
            check(attr_cnt == exp_attr, req, "attr select cycles", attr_cnt, exp_attr);
            if (t <= LIM - 1) begin
                check(done_at == t + 1 && done_n == 1, req, "done cycle", done_at, t + 1);
                check(err_n == 0, req, "err pulses", err_n, 0);
            end else begin
                check(err_at == LIM && err_n == 1, req, "err cycle", err_at, LIM);
                check(done_n == 0, req, "done pulses", done_n, 0);
            end
        end
        check(busy == 1'b0, req, "busy at end of window", busy, 0);
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check(!busy && !done && !err, "R1", "busy/done/err after reset", {busy, done, err}, 0);
        check(mem_oe_n && mem_we_n && io_rd_n && io_wr_n && attr_sel_n, "R1", "strobes after reset",
              {mem_oe_n, mem_we_n, io_rd_n, io_wr_n, attr_sel_n}, 5'b11111);
    endtask

    task automatic test_phases();
        run_access("R2", 2'b00, 1'b0, 2, 3, 1, 1'b0, 0, 0);
        run_access("R2", 2'b00, 1'b1, 5, 1, 4, 1'b0, 0, 0);
    endtask

    task automatic test_zero_counts();
        run_access("R3", 2'b00, 1'b0, 0, 0, 0, 1'b0, 0, 0);
        run_access("R3", 2'b10, 1'b1, 0, 3, 0, 1'b0, 0, 0);
    endtask

    task automatic test_spaces();
        run_access("R4", 2'b10, 1'b0, 1, 2, 1, 1'b0, 0, 0);
        run_access("R4", 2'b11, 1'b1, 2, 2, 2, 1'b0, 0, 0);
        run_access("R5", 2'b01, 1'b1, 1, 4, 2, 1'b0, 0, 0);
        run_access("R5", 2'b01, 1'b0, 3, 2, 3, 1'b0, 0, 0);
    endtask

    task automatic test_done_pulse();
        run_access("R6", 2'b00, 1'b1, 1, 1, 1, 1'b0, 0, 0);
    endtask

    task automatic test_bus_monitor();
        run_access("R7", 2'b00, 1'b0, 20, 20, 19, 1'b0, 0, 0);
        run_access("R7", 2'b00, 1'b0, 20, 20, 20, 1'b0, 0, 0);
        run_access("R7", 2'b01, 1'b1, 31, 31, 31, 1'b0, 0, 0);
    endtask

    task automatic test_busy_start();
        run_access("R8", 2'b00, 1'b0, 2, 2, 2, 1'b0, 3, 0);
        run_access("R8", 2'b01, 1'b1, 1, 3, 1, 1'b0, 5, 0);
    endtask

    task automatic test_oe_gate();
        run_access("R9", 2'b00, 1'b0, 2, 3, 2, 1'b1, 0, 0);
        run_access("R9", 2'b10, 1'b1, 1, 2, 1, 1'b1, 0, 0);
    endtask

    task automatic test_sock_reset();
        run_access("R10", 2'b00, 1'b0, 2, 5, 2, 1'b0, 0, 4);
        run_access("R10", 2'b10, 1'b1, 3, 3, 3, 1'b0, 0, 8);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL R0 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_phases();
        test_zero_counts();
        test_spaces();
        test_done_pulse();
        test_bus_monitor();
        test_busy_start();
        test_oe_gate();
        test_sock_reset();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule